// File: doc/BRIEF.md
# Prefixed Opcode Fetch Decoder

This block is the instruction-fetch front end of an 8-bit processor whose instruction set extends its 256 base opcodes with prefix bytes. It reads program bytes one at a time from a byte-wide memory port with a fixed one-cycle read latency. It strips any prefix bytes and hands the execute stage one flat opcode index. For the indexed bit-operation forms it also supplies the effective address formed from an index register and a signed displacement. An indication is raised when an extended-prefix opcode has no defined meaning.

The block owns the program counter and the 7-bit memory-refresh counter. It advances both as bytes are fetched. A ready/valid handshake towards the execute stage holds each decoded result, and holds fetch, until the result is taken. The next fetch is issued in the same cycle as the accept.

Top module: `pfd_fetch_decoder`

## Requirements
- R1: A synchronous reset sets `pc` and `refresh` to zero and deasserts `dec_valid`.
- R2: Each byte is requested with `mem_rd` high and `mem_addr` equal to `pc`. Its data is taken from `mem_rdata` one cycle later. `pc` rises by one, modulo 2^ADDR_W, for every byte requested, displacement bytes included.
- R3: `refresh` rises by one, modulo 128, for the first byte of every instruction and for the byte that follows a prefix. It does not rise for the displacement or for the final opcode byte of the indexed bit forms.
- R4: The prefix byte values are 0xCB (bit group), 0xDD (X-indexed), 0xED (extended) and 0xFD (Y-indexed). An unprefixed byte b yields index b. 0xCB b yields 256+b. 0xED b yields 512+b.
- R5: 0xDD b yields 768+b and 0xFD b yields 1280+b when b has an indexed meaning. These bytes have an indexed meaning: 09 19 21 22 23 24 25 26 29 2A 2B 2C 2D 2E 34 35 36 39 E1 E3 E5 E9 F9. So does any byte 40..7F other than 76 whose bits [5:3] or [2:0] are 4, 5 or 6, and any byte 80..BF whose bits [2:0] are 4, 5 or 6.
- R6: 0xDD b or 0xFD b, where b is neither 0xCB nor a byte with an indexed meaning, yields plain index b.
- R7: 0xDD 0xCB d op and 0xFD 0xCB d op yield index 1024+op. For these forms `dec_ea` is `ix_base` (DD) or `iy_base` (FD) plus d sign-extended, modulo 2^ADDR_W. For every other form `dec_ea` is zero.
- R8: `dec_illegal` is set only for 0xED b where b is not defined. The defined bytes are 40..7F except 77 and 7F, and A0..A3, A8..AB, B0..B3, B8..BB.
- R9: While `dec_valid` is high and `dec_ready` is low, the outputs hold and no byte is fetched. When a result is accepted, the first byte of the next instruction is requested in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ix_base | input | ADDR_W | X index register value |
| iy_base | input | ADDR_W | Y index register value |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rd | output | 1 | Byte read request |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| dec_valid | output | 1 | Decoded result available |
| dec_ready | input | 1 | Execute stage accepts the result |
| dec_index | output | INDEX_W | Flat opcode index |
| dec_ea | output | ADDR_W | Effective address for indexed bit forms |
| dec_illegal | output | 1 | Undefined extended opcode |
| pc | output | ADDR_W | Program counter |
| refresh | output | RFSH_W | Refresh counter |

## Verification
A wrong prefix register or a wrong state transition shows up as a wrong `dec_index` on the very next accepted result. It also misaligns every later instruction, so all following indices and `pc` values diverge. A miscounted refresh step shows as a `refresh` mismatch at the next accept and persists from then on. Stepping over the 128 boundary exposes a wrap fault. A displacement sign or width fault shows only on indexed bit forms, so these use negative, positive and address-wrapping displacements.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   localparam logic [7:0] PFX_BIT_BYTE = 8'hCB;
   localparam logic [7:0] PFX_X_BYTE   = 8'hDD;
   localparam logic [7:0] PFX_EXT_BYTE = 8'hED;
   localparam logic [7:0] PFX_Y_BYTE   = 8'hFD;

   localparam int unsigned OFS_PLAIN = 0;
   localparam int unsigned OFS_BIT   = 256;
   localparam int unsigned OFS_EXT   = 512;
   localparam int unsigned OFS_X     = 768;
   localparam int unsigned OFS_XYBIT = 1024;
   localparam int unsigned OFS_Y     = 1280;
   localparam int unsigned MIN_INDEX_W = 11;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_B1,
      ST_B2,
      ST_DISP,
      ST_B3,
      ST_HOLD
   } pfd_state_e;

   typedef enum logic [1:0] {
      PF_BIT,
      PF_X,
      PF_EXT,
      PF_Y
   } pfd_prefix_e;

endpackage

// File: rtl/pfd_op_class.sv
module pfd_op_class (
   input  logic [7:0] op,
   output logic       xy_ok,
   output logic       ext_ok
);

   logic [2:0] lo3;
   logic [2:0] mid3;
   logic       lo_hl;
   logic       mid_hl;

   assign lo3    = op[2:0];
   assign mid3   = op[5:3];
   assign lo_hl  = (lo3 == 3'd4) || (lo3 == 3'd5) || (lo3 == 3'd6);
   assign mid_hl = (mid3 == 3'd4) || (mid3 == 3'd5) || (mid3 == 3'd6);

   always_comb begin
      xy_ok = 1'b0;
      case (op[7:6])
         2'b00: begin
            case (op)
               8'h09, 8'h19, 8'h29, 8'h39,
               8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26,
               8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E,
               8'h34, 8'h35, 8'h36: xy_ok = 1'b1;
               default:             xy_ok = 1'b0;
            endcase
         end
         2'b01:   xy_ok = (op != 8'h76) && (lo_hl || mid_hl);
         2'b10:   xy_ok = lo_hl;
         default: begin
            case (op)
               8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9: xy_ok = 1'b1;
               default:                           xy_ok = 1'b0;
            endcase
         end
      endcase
   end

   always_comb begin
      ext_ok = 1'b0;
      if (op[7:6] == 2'b01) begin
         ext_ok = (op != 8'h77) && (op != 8'h7F);
      end else if (op[7:5] == 3'b101) begin
         ext_ok = ~op[2];
      end
   end

endmodule

// File: rtl/pfd_ea_calc.sv
module pfd_ea_calc #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (ADDR_W > DISP_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else if (ADDR_W == DISP_W) begin : g_same
         assign disp_ext = disp;
      end else begin : g_trunc
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   assign ea = base + disp_ext;

endmodule

// File: rtl/pfd_ctr.sv
module pfd_ctr #(
   parameter int ADDR_W = 16,
   parameter int RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_pc,
   input  logic              step_r,
   output logic [ADDR_W-1:0] pc_q,
   output logic [RFSH_W-1:0] r_q
);

   localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
   localparam logic [RFSH_W-1:0] R_ONE  = RFSH_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
         r_q  <= '0;
      end else begin
         if (step_pc) pc_q <= pc_q + PC_ONE;
         if (step_r)  r_q  <= r_q + R_ONE;
      end
   end

   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      step_pc |=> pc_q == $past(pc_q) + PC_ONE);

   p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !step_pc |=> $stable(pc_q));

   p_rfsh_step_r3: assert property (@(posedge clk) disable iff (rst)
      step_r |=> r_q == $past(r_q) + R_ONE);

   p_rfsh_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !step_r |=> $stable(r_q));

   p_rfsh_needs_fetch_r3: assert property (@(posedge clk) disable iff (rst)
      step_r |-> step_pc);

endmodule

// File: rtl/pfd_fetch_decoder.sv
module pfd_fetch_decoder
   import pfd_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int RFSH_W  = 7,
   parameter int INDEX_W = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  ix_base,
   input  logic [ADDR_W-1:0]  iy_base,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   input  logic [7:0]         mem_rdata,
   output logic               dec_valid,
   input  logic               dec_ready,
   output logic [INDEX_W-1:0] dec_index,
   output logic [ADDR_W-1:0]  dec_ea,
   output logic               dec_illegal,
   output logic [ADDR_W-1:0]  pc,
   output logic [RFSH_W-1:0]  refresh
);

   localparam int DISP_W = 8;
   localparam logic [INDEX_W-1:0] IDX_EXT_LO  = INDEX_W'(OFS_EXT);
   localparam logic [INDEX_W-1:0] IDX_EXT_HI  = INDEX_W'(OFS_X);
   localparam logic [INDEX_W-1:0] IDX_BIT_LO  = INDEX_W'(OFS_XYBIT);

   generate
      if (ADDR_W < DISP_W || ADDR_W > 32) begin : g_bad_addr
         $error("pfd_fetch_decoder: ADDR_W must lie in 8..32");
      end
      if (RFSH_W < 1 || RFSH_W > 8) begin : g_bad_rfsh
         $error("pfd_fetch_decoder: RFSH_W must lie in 1..8");
      end
      if (INDEX_W < MIN_INDEX_W) begin : g_bad_index
         $error("pfd_fetch_decoder: INDEX_W too small for the index space");
      end
   endgenerate

   function automatic logic [INDEX_W-1:0] mk_idx(input int unsigned ofs,
                                                 input logic [7:0] b);
      return INDEX_W'(ofs) + INDEX_W'(b);
   endfunction

   pfd_state_e  state_q, state_n;
   pfd_prefix_e pfx_q;
   logic [ADDR_W-1:0]  ea_hold_q;
   logic [INDEX_W-1:0] idx_q;
   logic [ADDR_W-1:0]  ea_out_q;
   logic               ill_q;

   logic               rd;
   logic               step_r;
   logic               ld;
   logic [INDEX_W-1:0] ld_idx;
   logic               ld_ill;
   logic               ld_use_ea;
   logic               cap_pfx;
   logic               cap_ea;

   logic               is_prefix;
   pfd_prefix_e        pfx_in;
   logic               xy_ok;
   logic               ext_ok;
   logic [ADDR_W-1:0]  ea_base;
   logic [ADDR_W-1:0]  ea_sum;

   pfd_op_class u_class (
      .op     (mem_rdata),
      .xy_ok  (xy_ok),
      .ext_ok (ext_ok)
   );

   assign ea_base = (pfx_q == PF_X) ? ix_base : iy_base;

   pfd_ea_calc #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_ea (
      .base (ea_base),
      .disp (mem_rdata),
      .ea   (ea_sum)
   );

   pfd_ctr #(
      .ADDR_W (ADDR_W),
      .RFSH_W (RFSH_W)
   ) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .step_pc (rd),
      .step_r  (step_r),
      .pc_q    (pc),
      .r_q     (refresh)
   );

   always_comb begin
      is_prefix = 1'b1;
      pfx_in    = PF_BIT;
      case (mem_rdata)
         PFX_BIT_BYTE: pfx_in = PF_BIT;
         PFX_X_BYTE:   pfx_in = PF_X;
         PFX_EXT_BYTE: pfx_in = PF_EXT;
         PFX_Y_BYTE:   pfx_in = PF_Y;
         default:      is_prefix = 1'b0;
      endcase
   end

   always_comb begin
      state_n   = state_q;
      rd        = 1'b0;
      step_r    = 1'b0;
      ld        = 1'b0;
      ld_idx    = '0;
      ld_ill    = 1'b0;
      ld_use_ea = 1'b0;
      cap_pfx   = 1'b0;
      cap_ea    = 1'b0;
      case (state_q)
         ST_BOOT: begin
            rd      = 1'b1;
            step_r  = 1'b1;
            state_n = ST_B1;
         end
         ST_B1: begin
            if (is_prefix) begin
               rd      = 1'b1;
               step_r  = 1'b1;
               cap_pfx = 1'b1;
               state_n = ST_B2;
            end else begin
               ld      = 1'b1;
               ld_idx  = mk_idx(OFS_PLAIN, mem_rdata);
               state_n = ST_HOLD;
            end
         end
         ST_B2: begin
            case (pfx_q)
               PF_BIT: begin
                  ld      = 1'b1;
                  ld_idx  = mk_idx(OFS_BIT, mem_rdata);
                  state_n = ST_HOLD;
               end
               PF_EXT: begin
                  ld      = 1'b1;
                  ld_idx  = mk_idx(OFS_EXT, mem_rdata);
                  ld_ill  = ~ext_ok;
                  state_n = ST_HOLD;
               end
               default: begin
                  if (mem_rdata == PFX_BIT_BYTE) begin
                     rd      = 1'b1;
                     state_n = ST_DISP;
                  end else begin
                     ld      = 1'b1;
                     state_n = ST_HOLD;
                     if (!xy_ok) begin
                        ld_idx = mk_idx(OFS_PLAIN, mem_rdata);
                     end else if (pfx_q == PF_X) begin
                        ld_idx = mk_idx(OFS_X, mem_rdata);
                     end else begin
                        ld_idx = mk_idx(OFS_Y, mem_rdata);
                     end
                  end
               end
            endcase
         end
         ST_DISP: begin
            rd      = 1'b1;
            cap_ea  = 1'b1;
            state_n = ST_B3;
         end
         ST_B3: begin
            ld        = 1'b1;
            ld_idx    = mk_idx(OFS_XYBIT, mem_rdata);
            ld_use_ea = 1'b1;
            state_n   = ST_HOLD;
         end
         ST_HOLD: begin
            if (dec_ready) begin
               rd      = 1'b1;
               step_r  = 1'b1;
               state_n = ST_B1;
            end
         end
         default: state_n = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_BOOT;
         pfx_q     <= PF_BIT;
         ea_hold_q <= '0;
         idx_q     <= '0;
         ea_out_q  <= '0;
         ill_q     <= 1'b0;
      end else begin
         state_q <= state_n;
         if (cap_pfx) pfx_q     <= pfx_in;
         if (cap_ea)  ea_hold_q <= ea_sum;
         if (ld) begin
            idx_q    <= ld_idx;
            ill_q    <= ld_ill;
            ea_out_q <= ld_use_ea ? ea_hold_q : '0;
         end
      end
   end

   assign mem_rd      = rd;
   assign mem_addr    = pc;
   assign dec_valid   = (state_q == ST_HOLD);
   assign dec_index   = idx_q;
   assign dec_ea      = ea_out_q;
   assign dec_illegal = ill_q;

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
      dec_valid && !dec_ready |=> dec_valid && $stable(dec_index)
                                  && $stable(dec_ea) && $stable(dec_illegal));

   p_no_fetch_stall_r9: assert property (@(posedge clk) disable iff (rst)
      dec_valid && !dec_ready |-> !mem_rd);

   p_accept_fetch_r9: assert property (@(posedge clk) disable iff (rst)
      dec_valid && dec_ready |-> mem_rd);

   p_ea_plain_r7: assert property (@(posedge clk) disable iff (rst)
      dec_valid && (dec_index < IDX_BIT_LO) |-> dec_ea == '0);

   p_illegal_ext_r8: assert property (@(posedge clk) disable iff (rst)
      dec_valid && dec_illegal |-> (dec_index >= IDX_EXT_LO) && (dec_index < IDX_EXT_HI));

   p_valid_after_reset_r1: assert property (@(posedge clk)
      rst |=> !dec_valid);

endmodule

// File: tb/pfd_fetch_decoder_bench.sv
module pfd_fetch_decoder_bench;

   localparam int ADDR_W  = 16;
   localparam int RFSH_W  = 7;
   localparam int INDEX_W = 11;
   localparam int MEM_N   = 1024;
   localparam int LIMIT   = 20000;

   typedef struct {
      int          idx;
      logic [15:0] ea;
      bit          ill;
      logic [15:0] pc_after;
      int          r_after;
      string       tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [ADDR_W-1:0]  ix_base = 16'hFFF0;
   logic [ADDR_W-1:0]  iy_base = 16'h0005;
   logic [ADDR_W-1:0]  mem_addr;
   logic               mem_rd;
   logic [7:0]         mem_rdata = 8'h00;
   logic               dec_valid;
   logic               dec_ready = 1'b0;
   logic [INDEX_W-1:0] dec_index;
   logic [ADDR_W-1:0]  dec_ea;
   logic               dec_illegal;
   logic [ADDR_W-1:0]  pc;
   logic [RFSH_W-1:0]  refresh;

   logic [7:0] mem [0:MEM_N-1];
   exp_t       sb_q[$];
   int         n_checks = 0;
   int         n_fail   = 0;
   int         cyc      = 0;
   int         wptr     = 0;
   int         exp_r    = 0;
   bit         mon_en   = 1'b0;

   always #2 clk = ~clk;

   pfd_fetch_decoder #(
      .ADDR_W  (ADDR_W),
      .RFSH_W  (RFSH_W),
      .INDEX_W (INDEX_W)
   ) u_pfd_fetch_decoder (
      .clk         (clk),
      .rst         (rst),
      .ix_base     (ix_base),
      .iy_base     (iy_base),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_rdata   (mem_rdata),
      .dec_valid   (dec_valid),
      .dec_ready   (dec_ready),
      .dec_index   (dec_index),
      .dec_ea      (dec_ea),
      .dec_illegal (dec_illegal),
      .pc          (pc),
      .refresh     (refresh)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
      dec_ready <= !((cyc % 7) == 2 || (cyc % 7) == 3);
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic insn(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3,
                       input int nb, input int m1, input int idx,
                       input logic [15:0] ea, input bit ill, input string tag);
      exp_t e;
      logic [7:0] bytes [4];
      bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
      for (int i = 0; i < nb; i++) begin
         mem[wptr] = bytes[i];
         wptr++;
      end
      exp_r = (exp_r + m1) % 128;
      e.idx = idx; e.ea = ea; e.ill = ill;
      e.pc_after = 16'(wptr); e.r_after = exp_r; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: pops one expected item per accepted result.
   always @(negedge clk) begin
      if (mon_en) begin
         if (dec_valid && !dec_ready) begin
            chk(mem_rd == 1'b0, "R9", "fetch during stall", mem_rd, 0);
         end
         if (dec_valid && dec_ready) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected result", dec_index, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(dec_index == INDEX_W'(e.idx), e.tag, "index", dec_index, e.idx);
               chk(dec_ea == e.ea, "R7", "ea", dec_ea, e.ea);
               chk(dec_illegal == e.ill, "R8", "illegal", dec_illegal, e.ill);
               chk(pc == e.pc_after, "R2", "pc", pc, e.pc_after);
               chk(refresh == RFSH_W'(e.r_after), "R3", "refresh", refresh, e.r_after);
               chk(mem_rd == 1'b1 && mem_addr == pc, "R9", "fetch on accept",
                   {mem_rd, mem_addr}, {1'b1, pc});
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
      // R4 plain, bit group, extended
      insn(8'h00, 8'h00, 8'h00, 8'h00, 1, 1, 0,    16'h0, 1'b0, "R4");
      insn(8'hCB, 8'h07, 8'h00, 8'h00, 2, 2, 263,  16'h0, 1'b0, "R4");
      insn(8'hED, 8'h44, 8'h00, 8'h00, 2, 2, 580,  16'h0, 1'b0, "R4");
      // R8 undefined and defined extended opcodes
      insn(8'hED, 8'h77, 8'h00, 8'h00, 2, 2, 631,  16'h0, 1'b1, "R8");
      insn(8'hED, 8'h00, 8'h00, 8'h00, 2, 2, 512,  16'h0, 1'b1, "R8");
      insn(8'hED, 8'hB0, 8'h00, 8'h00, 2, 2, 688,  16'h0, 1'b0, "R8");
      // R5 indexed meaning
      insn(8'hDD, 8'h21, 8'h00, 8'h00, 2, 2, 801,  16'h0, 1'b0, "R5");
      insn(8'hDD, 8'h64, 8'h00, 8'h00, 2, 2, 868,  16'h0, 1'b0, "R5");
      insn(8'hFD, 8'h86, 8'h00, 8'h00, 2, 2, 1414, 16'h0, 1'b0, "R5");
      // R6 fallback to plain meaning
      insn(8'hDD, 8'h76, 8'h00, 8'h00, 2, 2, 118,  16'h0, 1'b0, "R6");
      insn(8'hFD, 8'h3E, 8'h00, 8'h00, 2, 2, 62,   16'h0, 1'b0, "R6");
      // R7 indexed bit forms: wrap, negative, max positive displacement
      insn(8'hDD, 8'hCB, 8'h20, 8'h06, 4, 2, 1030, 16'h0010, 1'b0, "R7");
      insn(8'hFD, 8'hCB, 8'h80, 8'h46, 4, 2, 1094, 16'hFF85, 1'b0, "R7");
      insn(8'hDD, 8'hCB, 8'h7F, 8'hFE, 4, 2, 1278, 16'h006F, 1'b0, "R7");
      insn(8'h3E, 8'h00, 8'h00, 8'h00, 1, 1, 62,   16'h0, 1'b0, "R7");
      // R3 refresh wrap past 128
      for (int k = 0; k < 60; k++) begin
         insn(8'hCB, 8'h11, 8'h00, 8'h00, 2, 2, 273, 16'h0, 1'b0, "R3");
      end

      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dec_valid == 1'b0, "R1", "valid in reset", dec_valid, 0);
      chk(pc == '0, "R1", "pc in reset", pc, 0);
      chk(refresh == '0, "R1", "refresh in reset", refresh, 0);
      rst = 1'b0;
      #1;
      chk(mem_rd == 1'b1 && mem_addr == '0, "R2", "first fetch", {mem_rd, mem_addr}, 17'h10000);
      mon_en = 1'b1;

      while (sb_q.size() != 0 && cyc < LIMIT) @(posedge clk);
      @(negedge clk);
      if (sb_q.size() != 0) begin
         n_checks++;
         n_fail++;
         $display("FAIL R9 watchdog: actual %0d pending expected 0", sb_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule